// File: doc/BRIEF.md
# External Timestamp Counter

This block keeps a 48-bit running count of rising edges seen on an external timestamp clock. Another acquisition system can drive that clock, and events from both systems can then be matched by count. The external clock and a separate external clear line arrive with no timing relation to the system clock, which runs at 100 or 125 MHz. Each line passes through a synchronizer. An edge-detector state machine then turns each rising edge into a single-cycle pulse. The external clock is expected to stay at or below about 20 MHz, so the system clock sees every high and low phase.

An event trigger copies the current count into a holding register. The following cycle raises a one-cycle valid strobe for the downstream event writer. A separate snapshot request copies the count into a second register that the host can read. The two capture paths do not affect each other.

Each edge detector is a two-state machine. `ED_LOW` moves to `ED_HIGH` when the synchronized level is 1, and emits the rise pulse during that same cycle. `ED_HIGH` returns to `ED_LOW` when the level is 0. Every other case stays in the current state. The counter takes one of three operations each cycle: `CNT_ZERO` on a clear pulse, `CNT_STEP` on a count pulse, and `CNT_HOLD` otherwise. `CNT_ZERO` wins when both pulses occur together.

Top module: `ext_ts_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, the count, `ts_hold`, `ts_snap` are all zero and `ts_valid` is low.
- R2: Each 0-to-1 transition of `ext_clk_in` adds exactly one to the count. The new value first takes part in a capture at the fourth rising system-clock edge after the input changes; a capture at the third edge still sees the old value. A level held high or a falling edge adds nothing.
- R3: A 0-to-1 transition of `ext_clr_in` sets the count to zero with the same latency as R2. Holding the clear high afterwards does not stop later counting.
- R4: When a clear transition and a count transition are detected in the same cycle, the count becomes zero.
- R5: When `trig_in` is high at a clock edge, `ts_hold` takes the count value held just before that edge and `ts_valid` is high for the following cycle only. With `trig_in` low, `ts_hold` keeps its value and `ts_valid` is low.
- R6: Triggers on consecutive edges each overwrite `ts_hold`, and `ts_valid` stays high for every cycle after a trigger.
- R7: When `snap_req` is high at an edge, `ts_snap` takes the pre-edge count. Snapshots and triggers do not change each other's register.
- R8: The count wraps modulo 2^CNT_W from all ones to zero, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_in | input | 1 | External timestamp clock, asynchronous |
| ext_clr_in | input | 1 | External count clear, asynchronous, acts on rising edge |
| trig_in | input | 1 | Event trigger, one capture per high cycle |
| snap_req | input | 1 | Host snapshot request |
| ts_hold | output | CNT_W | Count captured by the latest trigger |
| ts_valid | output | 1 | One-cycle strobe after each trigger |
| ts_snap | output | CNT_W | Count captured by the latest snapshot request |

## Verification
A clear edge and a count edge can be detected in the same cycle. The bench provokes this by raising `ext_clr_in` and `ext_clk_in` on the same system cycle after the count has become nonzero, then reading the count through a snapshot. A result of zero confirms that the clear took priority. The same collision also occurs by chance during the random phase, where a cycle-level reference model judges the outcome. A trigger and a snapshot can also land on the same edge. The bench checks that each register receives the same pre-edge count.

// File: rtl/ets_pkg.sv
package ets_pkg;
    // edge-detector states: last synchronized level seen
    typedef enum logic {
        ED_LOW  = 1'b0,
        ED_HIGH = 1'b1
    } edge_state_t;

    // counter operation chosen each cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_STEP = 2'd1,
        CNT_ZERO = 2'd2
    } cnt_op_t;
endpackage

// File: rtl/ets_sync.sv
module ets_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ets_edge.sv
module ets_edge
    import ets_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);
    edge_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ED_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        rise_out = 1'b0;
        unique case (state_q)
            ED_LOW: begin
                if (level_in) begin
                    state_d  = ED_HIGH;
                    rise_out = 1'b1;
                end
            end
            ED_HIGH: begin
                if (!level_in) state_d = ED_LOW;
            end
        endcase
    end

    // R2: a held level yields one pulse, never two in a row
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_out |=> !rise_out);
endmodule

// File: rtl/ets_counter.sv
module ets_counter
    import ets_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_pulse,
    input  logic             clr_pulse,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_op_t op;

    always_comb begin
        if (clr_pulse)      op = CNT_ZERO;
        else if (inc_pulse) op = CNT_STEP;
        else                op = CNT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else begin
            unique case (op)
                CNT_ZERO: count <= '0;
                CNT_STEP: count <= count + ONE;
                default:  count <= count;
            endcase
        end
    end

    // R2 R8: a step adds one, wrapping at the top
    step_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse && !clr_pulse) |=> (count == $past(count) + ONE));

    // R3 R4: a clear pulse zeroes the count even with a step present
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (count == '0));

    // R2: no pulse, no change
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_pulse && !clr_pulse) |=> $stable(count));
endmodule

// File: rtl/ets_capture.sv
module ets_capture #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_in,
    input  logic             trig,
    input  logic             snap,
    output logic [CNT_W-1:0] hold_out,
    output logic             valid_out,
    output logic [CNT_W-1:0] snap_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_out  <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= trig;
            if (trig) hold_out <= count_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    snap_out <= '0;
        else if (snap) snap_out <= count_in;
    end

    // R5 R6: trigger captures the pre-edge count and raises valid
    trig_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (valid_out && hold_out == $past(count_in)));

    // R5: no trigger, no strobe, holding register untouched
    no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> (!valid_out && $stable(hold_out)));

    // R7: snapshot captures the pre-edge count
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (snap_out == $past(count_in)));

    // R7: no request leaves the snapshot unchanged
    snap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(snap_out));
endmodule

// File: rtl/ext_ts_counter.sv
module ext_ts_counter #(
    parameter int CNT_W       = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_in,
    input  logic             ext_clr_in,
    input  logic             trig_in,
    input  logic             snap_req,
    output logic [CNT_W-1:0] ts_hold,
    output logic             ts_valid,
    output logic [CNT_W-1:0] ts_snap
);
    localparam int N_LINES = 2;   // index 0: count clock, 1: clear

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic [N_LINES-1:0] rise_lines;
    logic [CNT_W-1:0]   count;

    assign raw_lines = {ext_clr_in, ext_clk_in};

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        ets_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_lines[i]),
            .sync_out (sync_lines[i])
        );
        ets_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (sync_lines[i]),
            .rise_out (rise_lines[i])
        );
    end

    ets_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_pulse (rise_lines[0]),
        .clr_pulse (rise_lines[1]),
        .count     (count)
    );

    ets_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_in  (count),
        .trig      (trig_in),
        .snap      (snap_req),
        .hold_out  (ts_hold),
        .valid_out (ts_valid),
        .snap_out  (ts_snap)
    );

    // R1: outputs idle right after reset
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ts_valid && ts_hold == '0 && ts_snap == '0));
endmodule

// File: tb/sim_ext_ts_counter.sv
module sim_ext_ts_counter;
    localparam int W  = 48;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_clk_in = 1'b0, ext_clr_in = 1'b0, trig_in = 1'b0, snap_req = 1'b0;
    logic [W-1:0]  hold0, snap0;
    logic [WS-1:0] hold1, snap1;
    logic          valid0, valid1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ext_ts_counter #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .ext_clr_in(ext_clr_in),
        .trig_in(trig_in), .snap_req(snap_req),
        .ts_hold(hold0), .ts_valid(valid0), .ts_snap(snap0));

    ext_ts_counter #(.CNT_W(WS)) u1 (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .ext_clr_in(ext_clr_in),
        .trig_in(trig_in), .snap_req(snap_req),
        .ts_hold(hold1), .ts_valid(valid1), .ts_snap(snap1));

    // reference state: value after the most recent posedge
    logic [W-1:0] m_cnt = '0, m_hold = '0, m_snap = '0;
    logic m_valid = 1'b0, m_prev_trig = 1'b0;
    logic m_c1 = 0, m_c2 = 0, m_cp = 0, m_r1 = 0, m_r2 = 0, m_rp = 0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        check(m_prev_trig ? "R6 hold" : "R5 hold", hold0, m_hold);
        check("R5 valid", {47'd0, valid0}, {47'd0, m_valid});
        check("R7 snap", snap0, m_snap);
        check("R8 narrow hold", {44'd0, hold1}, {44'd0, m_hold[WS-1:0]});
        check("R8 narrow snap", {44'd0, snap1}, {44'd0, m_snap[WS-1:0]});
    endtask

    // predicts the state after the coming posedge from the driven inputs
    task automatic model_step();
        logic crise, rrise;
        logic [W-1:0] cnt_now;
        crise = m_c2 & ~m_cp;
        rrise = m_r2 & ~m_rp;
        cnt_now = m_cnt;
        if (rrise)      m_cnt = '0;
        else if (crise) m_cnt = m_cnt + 1'b1;
        m_prev_trig = m_valid & trig_in;
        if (trig_in) m_hold = cnt_now;
        m_valid = trig_in;
        if (snap_req) m_snap = cnt_now;
        m_cp = m_c2; m_c2 = m_c1; m_c1 = ext_clk_in;
        m_rp = m_r2; m_r2 = m_r1; m_r1 = ext_clr_in;
    endtask

    task automatic cyc(input logic c, input logic r, input logic t, input logic s);
        @(negedge clk);
        compare_model();
        ext_clk_in = c; ext_clr_in = r; trig_in = t; snap_req = s;
        model_step();
    endtask

    task automatic cycn(input int n, input logic c, input logic r, input logic t, input logic s);
        for (int i = 0; i < n; i++) cyc(c, r, t, s);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240607);
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 hold", hold0, '0);
        check("R1 snap", snap0, '0);
        check("R1 valid", {47'd0, valid0}, '0);
        rst_n = 1'b1;

        // R2 latency: ext clock rises at call 1; count updates at P3
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 1);
        cyc(1, 0, 0, 1);
        cyc(1, 0, 0, 1);          // snap at P3 visible now
        check("R2 third edge still old", snap0, 48'd0);
        cyc(1, 0, 0, 0);          // snap at P4 visible now
        check("R2 fourth edge new", snap0, 48'd1);
        // R2: held level adds nothing
        cycn(4, 1, 0, 0, 0);
        cyc(1, 0, 0, 1);
        cyc(0, 0, 0, 0);
        check("R2 held high", snap0, 48'd1);
        cycn(4, 0, 0, 0, 0);
        // R4: clear and count rising together
        cycn(5, 1, 1, 0, 0);
        cyc(1, 1, 0, 1);
        cyc(1, 1, 0, 0);
        check("R4 clear priority", snap0, 48'd0);
        // R3: clear held high, counting continues
        cycn(4, 0, 1, 0, 0);
        cycn(4, 1, 1, 0, 0);
        cyc(1, 1, 0, 1);
        cyc(1, 1, 0, 0);
        check("R3 counting under held clear", snap0, 48'd1);
        // R3: clear edge alone zeroes
        cycn(3, 0, 0, 0, 0);
        cycn(4, 0, 1, 0, 0);
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, 0);
        check("R3 clear edge", snap0, 48'd0);
        // count to 1 then 2; count is 2 after the third cycle of the second high phase
        cycn(4, 1, 0, 0, 0);
        cycn(4, 0, 0, 0, 0);
        cyc(1, 0, 0, 0);          // A: rise input
        cyc(1, 0, 1, 0);          // B: trig at edge B, count still 1
        cyc(1, 0, 1, 0);          // C: count becomes 2 at this edge, captures 1
        check("R5 first capture", hold0, 48'd1);
        check("R5 valid after trig", {47'd0, valid0}, 48'd1);
        cyc(1, 0, 1, 0);          // D: captures 2
        cyc(1, 0, 0, 0);
        check("R6 overwrite hold", hold0, 48'd2);
        check("R6 valid stays", {47'd0, valid0}, 48'd1);
        cyc(0, 0, 0, 0);
        check("R5 strobe one cycle", {47'd0, valid0}, 48'd0);
        check("R7 snap untouched by trig", snap0, 48'd0);
        // R7: trigger and snapshot on the same edge
        cyc(0, 0, 1, 1);
        cyc(0, 0, 0, 0);
        check("R7 snap same edge", snap0, 48'd2);
        check("R7 hold same edge", hold0, 48'd2);

        // random phase, R8 wraps in the narrow instance
        for (int k = 0; k < 6000; k++) begin
            logic c, r, t, s;
            c = ext_clk_in;
            if ($urandom_range(2) == 0) c = ~c;
            r = ext_clr_in;
            if ($urandom_range(60) == 0) r = ~r;
            t = ($urandom_range(4) == 0);
            s = ($urandom_range(6) == 0);
            cyc(c, r, t, s);
        end
        cyc(0, 0, 0, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule